// File: doc/BRIEF.md
# Eight-bit bidirectional I/O port with mode-dependent strobe pins

This block is one general-purpose byte-wide I/O port for a small microcontroller bus. Software programs a per-pin direction (write-only) and a per-pin output latch (read/write), each at its own fixed byte address. The port turns these two registers into a pad output enable and a pad output value for each pin. It also returns a merged view of latch and pin levels when the CPU reads the data register.

In the expanded operating modes, pins 3, 4 and 5 are taken from the port and driven with the active-low read, write and address strobes that come from the bus controller. The two port registers keep their contents during this time and take effect again when the chip returns to single-chip mode. Pins 0 to 2 also feed the interrupt-request and converter-trigger logic. That tap uses the same latch/pin merge as a CPU read, so a pin set as an output can raise a trigger from software. Software should clear the direction bit of a pin that is used as a trigger input.

The pads are asynchronous to the core clock, so every pad input passes through a two-flop synchronizer before it reaches read-back or the trigger tap.

Top module: `pio_port8`

## Requirements
- R1: After reset, both registers hold 0x00. In single-chip mode this gives `pad_oe` = 0x00 and `pad_out` = 0x00.
- R2: A write (`bus_wr`=1) to address 0xFFB5 loads the direction register. From the next cycle, bit n = 1 makes pin n an output (`pad_oe[n]`=1) and bit n = 0 makes it an input, apart from the strobe override of R7.
- R3: A write to address 0xFFB7 loads all eight latch bits, whatever the direction of each pin. `pad_out` shows the new latch from the next cycle, apart from the strobe override of R7.
- R4: While `bus_rd`=1 and the address is 0xFFB7, bit n of `bus_rdata` is the latch bit if direction bit n is 1. If direction bit n is 0, it is the synchronized pin level.
- R5: The synchronized pin level lags `pad_in` by two clock edges. A pad change shows up on the third read sample that follows it, and not on the first or second.
- R6: A read of address 0xFFB5 returns 0xFF.
- R7: When `mode` is 1 or 2 (expanded), `pad_oe[5:3]` = 3'b111 and `pad_out[3]`, `pad_out[4]`, `pad_out[5]` equal `strb_rd_n`, `strb_wr_n`, `strb_as_n`. This holds whatever the register contents.
- R8: When `mode` is 3 (single-chip), pins 3 to 5 follow the direction and data registers like the other pins. The unused encoding 0 behaves the same way.
- R9: `irq_trig[n]` for n = 0..2 equals the latch bit when direction bit n is 1, and the synchronized pin level when it is 0.
- R10: A write to any other address changes neither register. A read of any other address, or any cycle with `bus_rd`=0, gives `bus_rdata` = 0x00.
- R11: The read-back rule of R4 also applies to pins 3 to 5 while they carry strobes in expanded mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | Operating mode: 1 or 2 expanded, 3 single-chip (0 treated as single-chip) |
| bus_addr | input | 16 | CPU byte address |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_rd | input | 1 | Read enable for the current address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| pad_in | input | 8 | Asynchronous pin levels from the pads |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin output value |
| strb_rd_n | input | 1 | Read strobe from the bus controller, active low |
| strb_wr_n | input | 1 | Write strobe from the bus controller, active low |
| strb_as_n | input | 1 | Address strobe from the bus controller, active low |
| irq_trig | output | 3 | Merged level of pins 0 to 2 for the interrupt and trigger logic |

## Verification
The bound checker checks these rules on every cycle:
- the strobe takeover in expanded modes;
- the fixed return values for direction-register reads and unmapped reads;
- the one-cycle visibility of register writes on pins 0 to 2;
- the two-edge lag of pin read-back;
- agreement between the trigger tap and the driven pin value when the direction bit is 1.

The bench's scenarios are needed for the rest:
- that writes to other addresses leave both registers untouched;
- that the latch survives an expanded-mode stretch and comes back in single-chip mode;
- the full merge across all eight bits under mixed directions, pin patterns and modes.

// File: rtl/pio_pkg.sv
package pio_pkg;

    typedef enum logic [1:0] {
        MODE_RSVD   = 2'd0,
        MODE_EXP_A  = 2'd1,
        MODE_EXP_B  = 2'd2,
        MODE_SINGLE = 2'd3
    } pio_mode_e;

    function automatic logic mode_is_expanded(input pio_mode_e m);
        return (m == MODE_EXP_A) || (m == MODE_EXP_B);
    endfunction

    localparam int unsigned NUM_STRB = 3;

endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q[0] <= '0;
        end else begin
            stage_q[0] <= din;
        end
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[s] <= '0;
                end else begin
                    stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/pio_regs.sv
module pio_regs #(
    parameter int unsigned        WIDTH    = 8,
    parameter int unsigned        AW       = 16,
    parameter logic [AW-1:0]      DIR_ADDR = 16'hFFB5,
    parameter logic [AW-1:0]      DAT_ADDR = 16'hFFB7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_wr,
    input  logic [WIDTH-1:0] bus_wdata,
    output logic             hit_dir,
    output logic             hit_dat,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] dat_q
);

    assign hit_dir = (bus_addr == DIR_ADDR);
    assign hit_dat = (bus_addr == DAT_ADDR);

    // direction register: write-only, all inputs after reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '0;
        end else if (bus_wr && hit_dir) begin
            dir_q <= bus_wdata;
        end
    end

    // output latch: every bit written regardless of direction
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dat_q <= '0;
        end else if (bus_wr && hit_dat) begin
            dat_q <= bus_wdata;
        end
    end

endmodule

// File: rtl/pio_readback.sv
module pio_readback #(
    parameter int unsigned WIDTH     = 8,
    parameter int unsigned TRIG_BITS = 3
) (
    input  logic                 bus_rd,
    input  logic                 hit_dir,
    input  logic                 hit_dat,
    input  logic [WIDTH-1:0]     dir_q,
    input  logic [WIDTH-1:0]     dat_q,
    input  logic [WIDTH-1:0]     pin_sync,
    output logic [WIDTH-1:0]     bus_rdata,
    output logic [TRIG_BITS-1:0] irq_trig
);

    logic [WIDTH-1:0] merged;

    // per bit: latch for outputs, synchronized pin for inputs
    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_merge
            assign merged[b] = dir_q[b] ? dat_q[b] : pin_sync[b];
        end
    endgenerate

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (hit_dat) begin
                bus_rdata = merged;
            end else if (hit_dir) begin
                bus_rdata = '1;
            end
        end
    end

    assign irq_trig = merged[TRIG_BITS-1:0];

endmodule

// File: rtl/pio_pinmux.sv
module pio_pinmux
    import pio_pkg::*;
#(
    parameter int unsigned WIDTH    = 8,
    parameter int unsigned STRB_LSB = 3
) (
    input  pio_mode_e            mode,
    input  logic [WIDTH-1:0]     dir_q,
    input  logic [WIDTH-1:0]     dat_q,
    input  logic [NUM_STRB-1:0]  strb_n,
    output logic [WIDTH-1:0]     pad_oe,
    output logic [WIDTH-1:0]     pad_out
);

    localparam int unsigned STRB_MSB = STRB_LSB + NUM_STRB - 1;

    logic expanded;
    assign expanded = mode_is_expanded(mode);

    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_pin
            if (b >= STRB_LSB && b <= STRB_MSB) begin : g_strb
                assign pad_oe[b]  = expanded ? 1'b1 : dir_q[b];
                assign pad_out[b] = expanded ? strb_n[b-STRB_LSB] : dat_q[b];
            end else begin : g_plain
                assign pad_oe[b]  = dir_q[b];
                assign pad_out[b] = dat_q[b];
            end
        end
    endgenerate

endmodule

// File: rtl/pio_port8.sv
module pio_port8
    import pio_pkg::*;
#(
    parameter int unsigned   WIDTH       = 8,
    parameter int unsigned   AW          = 16,
    parameter logic [AW-1:0] DIR_ADDR    = 16'hFFB5,
    parameter logic [AW-1:0] DAT_ADDR    = 16'hFFB7,
    parameter int unsigned   SYNC_STAGES = 2,
    parameter int unsigned   STRB_LSB    = 3,
    parameter int unsigned   TRIG_BITS   = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           mode,
    input  logic [AW-1:0]        bus_addr,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [WIDTH-1:0]     bus_wdata,
    output logic [WIDTH-1:0]     bus_rdata,
    input  logic [WIDTH-1:0]     pad_in,
    output logic [WIDTH-1:0]     pad_oe,
    output logic [WIDTH-1:0]     pad_out,
    input  logic                 strb_rd_n,
    input  logic                 strb_wr_n,
    input  logic                 strb_as_n,
    output logic [TRIG_BITS-1:0] irq_trig
);

    pio_mode_e            mode_e;
    logic [WIDTH-1:0]     dir_q;
    logic [WIDTH-1:0]     dat_q;
    logic [WIDTH-1:0]     pin_sync;
    logic                 hit_dir;
    logic                 hit_dat;
    logic [NUM_STRB-1:0]  strb_n;

    assign mode_e = pio_mode_e'(mode);
    // order: read strobe lowest, then write, then address strobe
    assign strb_n = {strb_as_n, strb_wr_n, strb_rd_n};

    pio_sync #(
        .WIDTH  (WIDTH),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pad_in),
        .dout (pin_sync)
    );

    pio_regs #(
        .WIDTH   (WIDTH),
        .AW      (AW),
        .DIR_ADDR(DIR_ADDR),
        .DAT_ADDR(DAT_ADDR)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .hit_dir  (hit_dir),
        .hit_dat  (hit_dat),
        .dir_q    (dir_q),
        .dat_q    (dat_q)
    );

    pio_readback #(
        .WIDTH    (WIDTH),
        .TRIG_BITS(TRIG_BITS)
    ) u_readback (
        .bus_rd   (bus_rd),
        .hit_dir  (hit_dir),
        .hit_dat  (hit_dat),
        .dir_q    (dir_q),
        .dat_q    (dat_q),
        .pin_sync (pin_sync),
        .bus_rdata(bus_rdata),
        .irq_trig (irq_trig)
    );

    pio_pinmux #(
        .WIDTH   (WIDTH),
        .STRB_LSB(STRB_LSB)
    ) u_pinmux (
        .mode   (mode_e),
        .dir_q  (dir_q),
        .dat_q  (dat_q),
        .strb_n (strb_n),
        .pad_oe (pad_oe),
        .pad_out(pad_out)
    );

endmodule

// File: rtl/pio_port8_chk.sv
module pio_port8_chk #(
    parameter int unsigned   WIDTH     = 8,
    parameter int unsigned   AW        = 16,
    parameter logic [AW-1:0] DIR_ADDR  = 16'hFFB5,
    parameter logic [AW-1:0] DAT_ADDR  = 16'hFFB7,
    parameter int unsigned   TRIG_BITS = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [1:0]           mode,
    input logic [AW-1:0]        bus_addr,
    input logic                 bus_wr,
    input logic                 bus_rd,
    input logic [WIDTH-1:0]     bus_wdata,
    input logic [WIDTH-1:0]     bus_rdata,
    input logic [WIDTH-1:0]     pad_in,
    input logic [WIDTH-1:0]     pad_oe,
    input logic [WIDTH-1:0]     pad_out,
    input logic                 strb_rd_n,
    input logic                 strb_wr_n,
    input logic                 strb_as_n,
    input logic [TRIG_BITS-1:0] irq_trig
);

    logic [1:0] since_rst;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    logic expd;
    assign expd = (mode == 2'd1) || (mode == 2'd2);

    a_r7_strobe_takeover: assert property (@(posedge clk) disable iff (!rst_n)
        expd |-> (pad_oe[5:3] == 3'b111) &&
                 (pad_out[5:3] == {strb_as_n, strb_wr_n, strb_rd_n}));

    a_r6_dir_reads_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == DIR_ADDR) |-> (bus_rdata == '1));

    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd || (bus_addr != DIR_ADDR && bus_addr != DAT_ADDR)) |-> (bus_rdata == '0));

    a_r2_dir_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == DIR_ADDR) |=> (pad_oe[2:0] == $past(bus_wdata[2:0])));

    a_r3_dat_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == DAT_ADDR) |=> (pad_out[2:0] == $past(bus_wdata[2:0])));

    a_r5_pin_lag: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && !pad_oe[0] && bus_rd && bus_addr == DAT_ADDR)
            |-> (bus_rdata[0] == $past(pad_in[0], 2)));

    a_r9_trig_follows_latch: assert property (@(posedge clk) disable iff (!rst_n)
        pad_oe[0] |-> (irq_trig[0] == pad_out[0]));

endmodule

bind pio_port8 pio_port8_chk #(
    .WIDTH    (WIDTH),
    .AW       (AW),
    .DIR_ADDR (DIR_ADDR),
    .DAT_ADDR (DAT_ADDR),
    .TRIG_BITS(TRIG_BITS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .pad_in   (pad_in),
    .pad_oe   (pad_oe),
    .pad_out  (pad_out),
    .strb_rd_n(strb_rd_n),
    .strb_wr_n(strb_wr_n),
    .strb_as_n(strb_as_n),
    .irq_trig (irq_trig)
);

// File: tb/tb_pio_port8.sv
module tb_pio_port8;

    localparam int          CLK_PERIOD = 10;
    localparam logic [15:0] A_DIR      = 16'hFFB5;
    localparam logic [15:0] A_DAT      = 16'hFFB7;
    localparam int          NVEC       = 8;

    // {mode[1:0], dir[7:0], dat[7:0], pin[7:0]}
    localparam logic [25:0] VEC [NVEC] = '{
        {2'd3, 8'hFF, 8'h5A, 8'h00},
        {2'd3, 8'h00, 8'hFF, 8'hC3},
        {2'd3, 8'h0F, 8'h3C, 8'hA5},
        {2'd1, 8'h00, 8'h00, 8'hFF},
        {2'd2, 8'hF0, 8'h0F, 8'h55},
        {2'd1, 8'h38, 8'hFF, 8'h00},
        {2'd0, 8'hC7, 8'h81, 8'h3E},
        {2'd2, 8'h07, 8'h05, 8'h02}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'd3;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [7:0]  pad_in = '0;
    logic [7:0]  pad_oe;
    logic [7:0]  pad_out;
    logic        strb_rd_n = 1'b0;
    logic        strb_wr_n = 1'b1;
    logic        strb_as_n = 1'b0;
    logic [2:0]  irq_trig;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pio_port8 dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .pad_in   (pad_in),
        .pad_oe   (pad_oe),
        .pad_out  (pad_out),
        .strb_rd_n(strb_rd_n),
        .strb_wr_n(strb_wr_n),
        .strb_as_n(strb_as_n),
        .irq_trig (irq_trig)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
        bus_addr = a;
        bus_rd   = 1'b1;
        #1;
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    function automatic logic expd(input logic [1:0] m);
        return (m == 2'd1) || (m == 2'd2);
    endfunction

    function automatic logic [7:0] mdl_oe(input logic [1:0] m, input logic [7:0] dir);
        return expd(m) ? (dir | 8'h38) : dir;
    endfunction

    function automatic logic [7:0] mdl_out(input logic [1:0] m, input logic [7:0] dat);
        return expd(m) ? ((dat & 8'hC7) | {2'b00, strb_as_n, strb_wr_n, strb_rd_n, 3'b000})
                       : dat;
    endfunction

    function automatic logic [7:0] mdl_rd(input logic [7:0] dir, input logic [7:0] dat,
                                          input logic [7:0] pin);
        return (dir & dat) | (~dir & pin);
    endfunction

    initial begin
        #(CLK_PERIOD * 50000);
        checks++;
        failures++;
        $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1: reset state
        chk("R1 oe", pad_oe, 8'h00);
        chk("R1 out", pad_out, 8'h00);
        bus_read(A_DAT, rd);
        chk("R1 read", rd, 8'h00);

        // table walk: R2 R3 R4 R7 R8 R9 R11
        for (int i = 0; i < NVEC; i++) begin
            logic [1:0] vm;
            logic [7:0] vdir, vdat, vpin;
            {vm, vdir, vdat, vpin} = VEC[i];
            mode   = vm;
            pad_in = vpin;
            bus_write(A_DIR, vdir);
            bus_write(A_DAT, vdat);
            repeat (2) @(negedge clk);
            chk(expd(vm) ? "R7 R2 oe" : "R8 R2 oe", pad_oe, mdl_oe(vm, vdir));
            chk(expd(vm) ? "R7 R3 out" : "R8 R3 out", pad_out, mdl_out(vm, vdat));
            bus_read(A_DAT, rd);
            chk(expd(vm) ? "R11 R4 read" : "R4 read", rd, mdl_rd(vdir, vdat, vpin));
            chk("R9 trig", {5'b0, irq_trig}, {5'b0, mdl_rd(vdir, vdat, vpin)[2:0]});
        end

        // R6: direction register reads as all ones
        bus_read(A_DIR, rd);
        chk("R6 dir read", rd, 8'hFF);

        // R10: unmapped address ignored on write, zero on read
        mode = 2'd3;
        bus_write(A_DIR, 8'h0F);
        bus_write(A_DAT, 8'h69);
        bus_write(16'hFFB6, 8'h96);
        bus_write(16'h00B7, 8'h00);
        @(negedge clk);
        chk("R10 out kept", pad_out, 8'h69);
        chk("R10 oe kept", pad_oe, 8'h0F);
        bus_read(16'hFFB6, rd);
        chk("R10 unmapped read", rd, 8'h00);
        chk("R10 no rd", bus_rdata, 8'h00);

        // R8: latch restored after an expanded stretch
        mode = 2'd2;
        @(negedge clk);
        chk("R7 strobe", pad_out, 8'h51);
        mode = 2'd3;
        #1;
        chk("R8 restore", pad_out, 8'h69);

        // R5: two-edge lag on pin read-back, all pins inputs
        bus_write(A_DIR, 8'h00);
        pad_in = 8'h00;
        repeat (3) @(negedge clk);
        pad_in = 8'hA5;
        bus_read(A_DAT, rd);
        chk("R5 lag0", rd, 8'h00);
        @(negedge clk);
        bus_read(A_DAT, rd);
        chk("R5 lag1", rd, 8'h00);
        @(negedge clk);
        bus_read(A_DAT, rd);
        chk("R5 lag2", rd, 8'hA5);

        // R9: trigger follows pin when input, latch when output
        chk("R9 pin", {5'b0, irq_trig}, 8'h05);
        bus_write(A_DAT, 8'h02);
        bus_write(A_DIR, 8'h07);
        chk("R9 latch", {5'b0, irq_trig}, 8'h02);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule